// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running timer value and compares it with a programmed compare value. When the two become equal, it takes the action that the selected 4-bit mode code calls for. It can toggle an output pin, drive the pin high, drive it low, raise only an interrupt flag, or fire a special event. The special event is a one-clock pulse that tells the timer to reset and tells an analog converter to start a conversion. The timer and the converter sit outside the block; the block only sees the timer count and only produces the two pulses.

A small state machine holds the active mode. Its states are OFF, TOGGLE, SET, CLEAR, FLAG and SPECIAL. On every clock the state register loads the state that the mode input decodes to. A clock on which the decoded state differs from the held state is an *entry* transition. On an entry the pin is initialised: high when entering CLEAR, low when entering any other state. Every compare action is suppressed on an entry clock. Once the mode is stable, a *match* transition runs the action of the held state, and the state itself does not change.

The interrupt flag stays set until software pulses the clear strobe. The flag is wiped whenever the block is off.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset, all five outputs are 0: `pin_out`, `pin_en`, `irq_flag`, `tmr_rst` and `adc_start`.
- R2: A match event occurs only on the first clock where `timer_val == cmp_val` (the value in the previous clock differed). It is not repeated while the two values stay equal. Its effects are visible after that clock edge.
- R3: In mode 4'b0010 (TOGGLE), `pin_en` is 1. Each match event inverts `pin_out` and sets `irq_flag`.
- R4: In mode 4'b1000 (SET), `pin_en` is 1. Entry drives `pin_out` to 0, and a match event drives it to 1 and sets `irq_flag`.
- R5: In mode 4'b1001 (CLEAR), `pin_en` is 1. Entry drives `pin_out` to 1, and a match event drives it to 0 and sets `irq_flag`.
- R6: In mode 4'b1010 (FLAG), `pin_en` is 0 and `pin_out` is 0. A match event only sets `irq_flag`.
- R7: In mode 4'b1011 (SPECIAL), a match event sets `irq_flag` and produces `tmr_rst` and `adc_start` together, each high for exactly one clock. `pin_en` is 0.
- R8: Mode 4'b0000, the reserved codes 4'b0001 and 4'b0011, and every other code not listed above select OFF. In OFF, `pin_en`, `pin_out`, `irq_flag`, `tmr_rst` and `adc_start` are 0, and matches are ignored.
- R9: `irq_flag` holds until a clock with `flag_clr` high clears it. A match event on the same clock as `flag_clr` leaves the flag set.
- R10: On the clock where the mode changes (entry), a coinciding equality produces no action. Only the entry initialisation applies, and equality that persists afterwards is not a new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Current timer count |
| cmp_val | input | 16 | Compare value |
| mode | input | 4 | Mode code |
| flag_clr | input | 1 | Clear strobe for the interrupt flag |
| pin_out | output | 1 | Output pin level |
| pin_en | output | 1 | 1 when the block drives the pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_rst | output | 1 | One-clock timer reset pulse |
| adc_start | output | 1 | One-clock conversion start pulse |

## Verification
Two pairs of events can land on the same clock. The first is a match and a flag clear. The bench raises `flag_clr` on the very clock the timer first equals the compare value, in CLEAR mode, and expects the flag to remain 1 while the pin falls. The second is a mode entry and an equality. The bench switches to SET with the timer already equal to the compare value, and expects only the entry level on the pin and no flag. It then holds the equality and expects no late match.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_TOGGLE,
        ST_SET,
        ST_CLEAR,
        ST_FLAG,
        ST_SPECIAL
    } cmu_state_e;

    localparam logic [MODE_W-1:0] CODE_TOGGLE  = 4'b0010;
    localparam logic [MODE_W-1:0] CODE_SET     = 4'b1000;
    localparam logic [MODE_W-1:0] CODE_CLEAR   = 4'b1001;
    localparam logic [MODE_W-1:0] CODE_FLAG    = 4'b1010;
    localparam logic [MODE_W-1:0] CODE_SPECIAL = 4'b1011;

    function automatic cmu_state_e decode_mode(input logic [MODE_W-1:0] code);
        cmu_state_e st;
        case (code)
            CODE_TOGGLE:  st = ST_TOGGLE;
            CODE_SET:     st = ST_SET;
            CODE_CLEAR:   st = ST_CLEAR;
            CODE_FLAG:    st = ST_FLAG;
            CODE_SPECIAL: st = ST_SPECIAL;
            default:      st = ST_OFF;
        endcase
        return st;
    endfunction
endpackage

// File: rtl/cmu_match_det.sv
module cmu_match_det #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] cmp_val,
    input  logic          arm,
    output logic          evt
);
    logic eq_now;
    logic eq_prev;

    assign eq_now = (timer_val == cmp_val);

    // previous equality is tracked in every mode so that a held equality is never new
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eq_prev <= 1'b0;
        else        eq_prev <= eq_now;
    end

    assign evt = arm && eq_now && !eq_prev;

    // R2: a match event never repeats on the next clock
    assert_no_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/cmu_mode_fsm.sv
module cmu_mode_fsm
    import cmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              evt,
    output cmu_state_e        state_q,
    output logic              entering,
    output logic              wipe,
    output logic              flag_set,
    output logic              pin_out,
    output logic              pin_en,
    output logic              tmr_rst,
    output logic              adc_start
);
    cmu_state_e next_state;
    logic       pin_q;
    logic       tmr_q;
    logic       adc_q;

    assign next_state = decode_mode(mode);
    assign entering   = (next_state != state_q);
    assign wipe       = (next_state == ST_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= next_state;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            tmr_q <= 1'b0;
            adc_q <= 1'b0;
        end else begin
            tmr_q <= 1'b0;
            adc_q <= 1'b0;
            if (entering) begin
                pin_q <= (next_state == ST_CLEAR);
            end else if (evt) begin
                unique case (state_q)
                    ST_TOGGLE:  pin_q <= ~pin_q;
                    ST_SET:     pin_q <= 1'b1;
                    ST_CLEAR:   pin_q <= 1'b0;
                    ST_SPECIAL: begin
                        tmr_q <= 1'b1;
                        adc_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        flag_set = evt && (state_q != ST_OFF);
        pin_en   = (state_q == ST_TOGGLE) || (state_q == ST_SET) || (state_q == ST_CLEAR);
    end

    assign pin_out   = pin_q;
    assign tmr_rst   = tmr_q;
    assign adc_start = adc_q;

    // R7: special-event pulses last one clock and always come as a pair
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst |=> !tmr_rst);
    assert_pulse_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst == adc_start);
    // R4: entering SET leaves the pin low
    assert_set_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (entering && next_state == ST_SET) |=> !pin_out);
    // R5: entering CLEAR leaves the pin high
    assert_clear_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (entering && next_state == ST_CLEAR) |=> pin_out);
    // R10: an entry clock never fires the special event
    assert_entry_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        entering |=> !tmr_rst);
endmodule

// File: rtl/cmu_irq_flag.sv
module cmu_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic wipe,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    irq <= 1'b0;
        else if (wipe) irq <= 1'b0;
        else if (set)  irq <= 1'b1;
        else if (clr)  irq <= 1'b0;
    end

    // R9: a match beats a simultaneous clear
    assert_match_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set && clr && !wipe) |=> irq);
    // R9: without a clear the flag holds
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr && !wipe) |=> irq);
    // R8: off mode wipes the flag
    assert_off_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> !irq);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
    import cmu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_val,
    input  logic [TW-1:0]     cmp_val,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    output logic              pin_out,
    output logic              pin_en,
    output logic              irq_flag,
    output logic              tmr_rst,
    output logic              adc_start
);
    cmu_state_e state_q;
    logic       entering;
    logic       wipe;
    logic       flag_set;
    logic       evt;
    logic       arm;

    assign arm = !entering && (state_q != ST_OFF);

    cmu_match_det #(.TW(TW)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_val (timer_val),
        .cmp_val   (cmp_val),
        .arm       (arm),
        .evt       (evt)
    );

    cmu_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .evt       (evt),
        .state_q   (state_q),
        .entering  (entering),
        .wipe      (wipe),
        .flag_set  (flag_set),
        .pin_out   (pin_out),
        .pin_en    (pin_en),
        .tmr_rst   (tmr_rst),
        .adc_start (adc_start)
    );

    cmu_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .wipe  (wipe),
        .irq   (irq_flag)
    );

    // R8: in the off state nothing is driven or flagged
    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!pin_en && !irq_flag && !tmr_rst && !adc_start));
endmodule

// File: tb/cmp_match_unit_bench.sv
`timescale 1ns/1ps
module cmp_match_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic [15:0] cmp_val = 16'd100;
    logic [3:0]  mode = 4'b0000;
    logic        flag_clr = 1'b0;
    logic        pin_out, pin_en, irq_flag, tmr_rst, adc_start;

    typedef struct {
        logic [4:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    cmp_match_unit u_cmp_match_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_val (timer_val),
        .cmp_val   (cmp_val),
        .mode      (mode),
        .flag_clr  (flag_clr),
        .pin_out   (pin_out),
        .pin_en    (pin_en),
        .irq_flag  (irq_flag),
        .tmr_rst   (tmr_rst),
        .adc_start (adc_start)
    );

    // driver: apply inputs away from the edge and queue the result expected after it
    task automatic step(input logic [15:0] tv, input logic [3:0] md, input logic clr,
                        input logic [4:0] expv, input string tag);
        @(negedge clk);
        timer_val = tv;
        mode      = md;
        flag_clr  = clr;
        exp_q.push_back('{vec: expv, tag: tag});
    endtask

    // monitor: compare after each rising edge; vector = {pin,en,irq,tmr,adc}
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [4:0] got;
            e   = exp_q.pop_front();
            got = {pin_out, pin_en, irq_flag, tmr_rst, adc_start};
            checks++;
            if (got !== e.vec) begin
                errors++;
                $display("FAIL %s: got pin/en/irq/tmr/adc=%b expected %b", e.tag, got, e.vec);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(16'd0,   4'b0000, 1'b0, 5'b00000, "R1 reset state");
        step(16'd0,   4'b0010, 1'b0, 5'b01000, "R10 toggle entry");
        step(16'd100, 4'b0010, 1'b0, 5'b11100, "R3 toggle first match");
        step(16'd100, 4'b0010, 1'b0, 5'b11100, "R2 held equality no repeat");
        step(16'd101, 4'b0010, 1'b0, 5'b11100, "R3 no match");
        step(16'd100, 4'b0010, 1'b0, 5'b01100, "R3 toggle second match");
        step(16'd5,   4'b0010, 1'b1, 5'b01000, "R9 clear strobe");
        step(16'd6,   4'b0010, 1'b0, 5'b01000, "R9 stays cleared");
        step(16'd100, 4'b1000, 1'b0, 5'b01000, "R10 entry with equality ignored");
        step(16'd100, 4'b1000, 1'b0, 5'b01000, "R10 held equality after entry");
        step(16'd7,   4'b1000, 1'b0, 5'b01000, "R4 idle");
        step(16'd100, 4'b1000, 1'b0, 5'b11100, "R4 set on match");
        step(16'd8,   4'b1000, 1'b0, 5'b11100, "R9 sticky flag");
        step(16'd100, 4'b1001, 1'b0, 5'b11100, "R5 clear entry high");
        step(16'd9,   4'b1001, 1'b0, 5'b11100, "R5 idle");
        step(16'd100, 4'b1001, 1'b1, 5'b01100, "R9 match wins over clear");
        step(16'd0,   4'b1010, 1'b0, 5'b00100, "R6 flag-only entry");
        step(16'd0,   4'b1010, 1'b1, 5'b00000, "R6 clear");
        step(16'd100, 4'b1010, 1'b0, 5'b00100, "R6 flag-only match");
        step(16'd0,   4'b1011, 1'b1, 5'b00000, "R7 special entry");
        step(16'd100, 4'b1011, 1'b0, 5'b00111, "R7 special pulses");
        step(16'd100, 4'b1011, 1'b0, 5'b00100, "R7 pulses single clock");
        step(16'd0,   4'b0011, 1'b0, 5'b00000, "R8 reserved code off");
        step(16'd100, 4'b0011, 1'b0, 5'b00000, "R8 match ignored");
        step(16'd3,   4'b0001, 1'b0, 5'b00000, "R8 reserved 0001");
        step(16'd100, 4'b0001, 1'b0, 5'b00000, "R8 match ignored 0001");
        step(16'd4,   4'b1100, 1'b0, 5'b00000, "R8 unlisted code");
        step(16'd100, 4'b1100, 1'b0, 5'b00000, "R8 unlisted code match");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule